// File: doc/BRIEF.md
# Six-Channel Down-Counting Interval Timer Bank

This block holds six independent down-counting timers behind a simple word-addressed register port. Each channel has three words: a control word, an interval word that supplies the reload value, and a count word that shows the live counter. The channels share one interrupt-enable word and one interrupt-status word. Every channel drives its own interrupt line, which pulses for one clock cycle each time that channel expires.

All counters advance on a shared `tick` strobe that comes from an external prescaler. A channel runs in one of two modes. In periodic mode it reloads from its interval word and keeps running. In one-shot mode it stops and drops its own enable bit. Software clears status bits by writing ones to them. The block also holds two 32-bit watchdog words. These only store what is written to them and have no effect on the timers.

Top module: `timer_bank`

## Requirements
- R1: The register map is as follows. Byte offset 0x00 is interrupt enable (6 bits, read/write) and 0x04 is interrupt status. Channel i (0..5) owns a 16-byte slot at 0x10·(i+1), so the channel index is offset bits [7:4] minus one. Within a slot, +0x0 is control, +0x4 is interval and +0x8 is count. Offsets 0x80 and 0x84 are plain 32-bit storage words. Every other offset reads as zero.
- R2: After reset, interrupt enable, status, every interval, every count, both storage words and the `irq` lines are zero, and every control word reads 0x04.
- R3: A write to the status word clears each status bit written as 1 and leaves each bit written as 0 unchanged.
- R4: A control write with bit 1 (reload) set loads the channel's count from its current interval word.
- R5: Control bit 0 (enable) runs the channel, and the count then drops by one on each `tick`. While enable is 0, the count holds its value.
- R6: A running channel expires on a `tick` when its count is 0 or 1. On expiry, status bit i is set and `irq[i]` is high for the following cycle. In periodic mode (control bit 7 = 0) the count reloads from the interval word.
- R7: In one-shot mode (control bit 7 = 1), expiry sets the count to 0 and clears control bit 0. All other control bits keep their values.
- R8: Reading the count word returns the live counter. Writing the count word loads the counter directly.
- R9: When an expiry and a status clear hit the same bit in the same cycle, the bit ends up set. When a control write and an expiry hit the same channel in the same cycle, the control write decides the channel's control word and count.
- R10: `rdata` is a combinational function of `addr` and the register state. A write takes effect at the clock edge where `wr_en` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Prescaled count strobe shared by all channels |
| wr_en | input | 1 | Write strobe for the word at `addr` |
| addr | input | 8 | Byte offset of the accessed word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 6 | Per-channel one-cycle expiry pulses |

## Verification
Every result in this block appears one clock edge after the stimulus that causes it. This covers a write, a `tick` that decrements, reloads or expires a counter, a status set or clear, and the `irq` pulse. `rdata` then shows the new state with no further delay. The bench therefore applies each stimulus at the falling edge. It lets one rising edge pass and samples both `irq` and `rdata` two nanoseconds later. It compares them with a cycle model that the bench advances at that same rising edge. Reading the same word that was just written gives a read-after-write check within that same cycle.

// File: rtl/timer_bank.sv
module timer_bank #(
  parameter int NCH      = 6,
  parameter int DW       = 32,
  parameter int AW       = 8,
  parameter logic [7:0] CTRL_RST = 8'h04
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [NCH-1:0] irq
);
  localparam int UW = AW - 4;
  localparam int B_EN = 0, B_RL = 1, B_MD = 7;
  localparam logic [AW-1:0] OFF_IEN = AW'(8'h00);
  localparam logic [AW-1:0] OFF_STS = AW'(8'h04);
  localparam logic [AW-1:0] OFF_WD0 = AW'(8'h80);
  localparam logic [AW-1:0] OFF_WD1 = AW'(8'h84);

  logic [7:0]    ctrl [NCH];
  logic [DW-1:0] ival [NCH];
  logic [DW-1:0] cnt  [NCH];
  logic [NCH-1:0] ien, sts, irq_q, expire, sts_clr;
  logic [NCH-1:0] wr_ctl, wr_ivl, wr_cnt;
  logic [DW-1:0] wd0, wd1;

  wire [UW-1:0] slot = addr[AW-1:4];
  wire [3:0]    sub  = addr[3:0];

  assign sts_clr = (wr_en && addr == OFF_STS) ? wdata[NCH-1:0] : '0;
  assign irq     = irq_q;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      expire[i] = tick && ctrl[i][B_EN] && (cnt[i] <= DW'(1));
      wr_ctl[i] = wr_en && slot == UW'(i + 1) && sub == 4'h0;
      wr_ivl[i] = wr_en && slot == UW'(i + 1) && sub == 4'h4;
      wr_cnt[i] = wr_en && slot == UW'(i + 1) && sub == 4'h8;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien   <= '0;
      sts   <= '0;
      irq_q <= '0;
      wd0   <= '0;
      wd1   <= '0;
      for (int i = 0; i < NCH; i++) begin
        ctrl[i] <= CTRL_RST;
        ival[i] <= '0;
        cnt[i]  <= '0;
      end
    end else begin
      irq_q <= expire;
      sts   <= (sts & ~sts_clr) | expire;
      if (wr_en && addr == OFF_IEN) ien <= wdata[NCH-1:0];
      if (wr_en && addr == OFF_WD0) wd0 <= wdata;
      if (wr_en && addr == OFF_WD1) wd1 <= wdata;
      for (int i = 0; i < NCH; i++) begin
        if (expire[i]) begin
          if (ctrl[i][B_MD]) begin
            cnt[i]        <= '0;
            ctrl[i][B_EN] <= 1'b0;
          end else begin
            cnt[i] <= ival[i];
          end
        end else if (tick && ctrl[i][B_EN]) begin
          cnt[i] <= cnt[i] - DW'(1);
        end
        if (wr_ivl[i]) ival[i] <= wdata;
        if (wr_cnt[i]) cnt[i] <= wdata;
        if (wr_ctl[i]) begin
          ctrl[i] <= wdata[7:0];
          if (wdata[B_RL]) cnt[i] <= ival[i];
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFF_IEN: rdata = DW'(ien);
      OFF_STS: rdata = DW'(sts);
      OFF_WD0: rdata = wd0;
      OFF_WD1: rdata = wd1;
      default: ;
    endcase
    for (int i = 0; i < NCH; i++) begin
      if (slot == UW'(i + 1)) begin
        case (sub)
          4'h0: rdata = DW'(ctrl[i]);
          4'h4: rdata = ival[i];
          4'h8: rdata = cnt[i];
          default: ;
        endcase
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    assert_irq_has_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q[g] |-> sts[g]);
    assert_oneshot_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (expire[g] && ctrl[g][B_MD] && !wr_ctl[g] && !wr_cnt[g])
        |=> (!ctrl[g][B_EN] && cnt[g] == '0));
    assert_idle_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl[g][B_EN] && !wr_ctl[g] && !wr_cnt[g]) |=> $stable(cnt[g]));
    assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_clr[g] && !expire[g]) |=> !sts[g]);
  end
endmodule

// File: tb/tb_timer_bank.sv
`timescale 1ns/1ps
module tb_timer_bank;
  localparam int NCH = 6;
  logic clk = 0, rst_n = 0, tick = 0, wr_en = 0;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic [NCH-1:0] irq;
  int vecs = 0, errs = 0, cycles = 0;

  timer_bank dut (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
                  .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  always #5 clk = ~clk;

  logic [7:0]  m_ctrl [NCH];
  logic [31:0] m_ival [NCH];
  logic [31:0] m_cnt  [NCH];
  logic [NCH-1:0] m_ien, m_sts, m_irq;
  logic [31:0] m_wd0, m_wd1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ien = 0; m_sts = 0; m_irq = 0; m_wd0 = 0; m_wd1 = 0;
      for (int c = 0; c < NCH; c++) begin
        m_ctrl[c] = 8'h04; m_ival[c] = 0; m_cnt[c] = 0;
      end
    end else begin
      logic [NCH-1:0] setv, clrv;
      clrv = (wr_en && addr == 8'h04) ? wdata[NCH-1:0] : '0;
      for (int c = 0; c < NCH; c++) begin
        logic [7:0] base;
        base = 8'(16 * (c + 1));
        setv[c] = tick && m_ctrl[c][0] && m_cnt[c] <= 1;
        if (setv[c]) begin
          if (m_ctrl[c][7]) begin m_cnt[c] = 0; m_ctrl[c][0] = 0; end
          else m_cnt[c] = m_ival[c];
        end else if (tick && m_ctrl[c][0]) m_cnt[c] = m_cnt[c] - 1;
        if (wr_en && addr == base + 8'h8) m_cnt[c] = wdata;
        if (wr_en && addr == base) begin
          m_ctrl[c] = wdata[7:0];
          if (wdata[1]) m_cnt[c] = m_ival[c];
        end
        if (wr_en && addr == base + 8'h4) m_ival[c] = wdata;
      end
      if (wr_en && addr == 8'h00) m_ien = wdata[NCH-1:0];
      if (wr_en && addr == 8'h80) m_wd0 = wdata;
      if (wr_en && addr == 8'h84) m_wd1 = wdata;
      m_sts = (m_sts & ~clrv) | setv;
      m_irq = setv;
    end
  end

  function automatic logic [31:0] mread(logic [7:0] a);
    int s;
    s = int'(a[7:4]);
    if (a == 8'h00) return 32'(m_ien);
    if (a == 8'h04) return 32'(m_sts);
    if (a == 8'h80) return m_wd0;
    if (a == 8'h84) return m_wd1;
    if (s >= 1 && s <= NCH) begin
      if (a[3:0] == 4'h0) return 32'(m_ctrl[s-1]);
      if (a[3:0] == 4'h4) return m_ival[s-1];
      if (a[3:0] == 4'h8) return m_cnt[s-1];
    end
    return 0;
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    vecs++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s addr=%h got=%h expected=%h t=%0t", tag, addr, got, exp, $time);
    end
  endtask

  task automatic cyc(bit we, logic [7:0] a, logic [31:0] d, bit tk, string tag);
    @(negedge clk);
    wr_en = we; addr = a; wdata = d; tick = tk;
    @(posedge clk);
    #2;
    check({tag, " irq"}, 32'(irq), 32'(m_irq));
    check({tag, " rdata"}, rdata, mread(a));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      errs++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    logic [7:0] alist [12];
    alist = '{8'h00, 8'h04, 8'h10, 8'h14, 8'h18, 8'h20, 8'h24, 8'h28,
              8'h60, 8'h68, 8'h80, 8'h84};
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    #2;
    check("R2 irq at reset", 32'(irq), 0);
    rst_n = 1;
    for (int s = 0; s < 16; s++)
      for (int k = 0; k < 16; k += 4) cyc(0, 8'(16 * s + k), 0, 0, "R2");
    // R1: distinct intervals per slot, holes read zero
    for (int c = 0; c < NCH; c++) cyc(1, 8'(16 * (c + 1) + 4), 32'(100 + c), 0, "R1");
    for (int c = 0; c < NCH; c++) cyc(0, 8'(16 * (c + 1) + 4), 0, 0, "R1");
    cyc(0, 8'h1C, 0, 0, "R1"); cyc(0, 8'h70, 0, 0, "R1"); cyc(0, 8'h0C, 0, 0, "R1");
    cyc(1, 8'h80, 32'hDEADBEEF, 0, "R1"); cyc(1, 8'h84, 32'h12345678, 0, "R1");
    cyc(1, 8'h00, 32'h2A, 0, "R1");
    // R4 reload
    cyc(1, 8'h34, 5, 0, "R4"); cyc(1, 8'h30, 32'h02, 1, "R4"); cyc(0, 8'h38, 0, 0, "R4");
    // R5 run and hold
    cyc(1, 8'h30, 32'h01, 0, "R5");
    repeat (3) cyc(0, 8'h38, 0, 1, "R5");
    cyc(1, 8'h30, 32'h00, 1, "R5");
    repeat (3) cyc(0, 8'h38, 0, 1, "R5");
    // R6 periodic expiry and pulses
    cyc(1, 8'h14, 3, 0, "R6"); cyc(1, 8'h10, 32'h03, 0, "R6");
    repeat (8) cyc(0, 8'h04, 0, 1, "R6");
    cyc(1, 8'h10, 0, 0, "R6");
    // R7 one-shot
    cyc(1, 8'h24, 2, 0, "R7"); cyc(1, 8'h20, 32'h87, 0, "R7");
    repeat (4) cyc(0, 8'h20, 0, 1, "R7");
    cyc(0, 8'h28, 0, 0, "R7");
    // R3 write-one-to-clear
    cyc(1, 8'h04, 32'h01, 0, "R3"); cyc(1, 8'h04, 32'h3F, 0, "R3");
    // R8 count write and live read
    cyc(1, 8'h58, 9, 0, "R8"); cyc(1, 8'h50, 32'h01, 1, "R8");
    repeat (3) cyc(0, 8'h58, 0, 1, "R8");
    cyc(1, 8'h50, 0, 0, "R8");
    // R9 precedence
    cyc(1, 8'h44, 1, 0, "R9"); cyc(1, 8'h40, 32'h03, 0, "R9");
    cyc(1, 8'h04, 32'h3F, 1, "R9"); cyc(0, 8'h04, 0, 0, "R9");
    cyc(1, 8'h40, 32'h83, 1, "R9"); cyc(0, 8'h48, 0, 0, "R9");
    cyc(1, 8'h40, 0, 0, "R9");
    // R10 random mix
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] a;
      logic [31:0] d;
      bit we;
      a = alist[$urandom_range(0, 11)];
      we = ($urandom_range(0, 9) < 4);
      if (a[3:0] == 4'h0 && a[7:4] != 0 && a[7:4] != 8) d = $urandom & 32'h83;
      else if (a == 8'h80 || a == 8'h84) d = $urandom;
      else if (a == 8'h00 || a == 8'h04) d = 32'($urandom_range(0, 63));
      else d = 32'($urandom_range(0, 6));
      cyc(we, a, d, $urandom_range(0, 1) == 1, "R10");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule